// File: doc/BRIEF.md
# I2C Target Interface Core with Byte Status Flags

This core is the target (slave) side of a two-wire I2C bus using 7-bit addresses. It samples SCL and SDA with the system clock and passes each line through a synchronizer and an agreement filter. It then detects START, repeated START and STOP conditions and moves bytes in and out one bit per SCL clock. When the first byte after a START carries the core's own address, the core acknowledges it. After that it either takes in data bytes from the controller or sends bytes from its data register to the controller.

A host handler services the core through a single byte-wide data register, a set of status flags and a one-cycle event pulse. The event fires once per byte-level step: an address match, a data byte received, or a transmitted byte that the controller has acknowledged or refused. The flags let the handler tell these cases apart. The read/write flag drops back to the write value when the controller refuses a transmitted byte, so the handler can see that the read is over. Sticky overflow and collision flags record handler mistakes until the handler clears them. Clock stretching, general call and 10-bit addressing are not part of this core. The pads are modelled as a plain input plus a drive-low enable.

Top module: `i2c_target_core`

## Requirements
- R1: A START (SDA falling while SCL is high) sets `st_start` and clears `st_stop`. A STOP (SDA rising while SCL is high) sets `st_stop` and clears `st_start`. The two flags are never high together.
- R2: The first byte after a START is the address. The top 7 bits come first, MSB first, and bit 0 is R/W with 1 meaning read. The core drives `sda_oe` high (SDA low) during the 9th clock only when the top 7 bits equal `own_addr`. On any other address it gives no ACK and no event, and it ignores the bus until the next START or STOP.
- R3: `evt` is a one-cycle pulse at the rising SCL edge of the 9th (acknowledge) clock. It fires after a matched address, after every received data byte, and after every transmitted byte, whether the controller answered with ACK or NACK.
- R4: At each event, `st_data` is 0 for an address byte and 1 for a data byte, and `st_read` equals the R/W bit of the matched address.
- R5: A received data byte appears on `rd_data`, `st_full` goes to 1 and the core ACKs the byte. A `rd_stb` pulse while `st_read` is 0 clears `st_full`. Address bytes are not placed in the data register.
- R6: If a data byte completes while `st_full` is 1, `st_ovf` is set, the data register keeps its old byte and the byte is not acknowledged. `st_ovf` stays set until a `clr_ovf` pulse.
- R7: In read mode the core sends the data register's contents as they stand when the acknowledge clock ends, MSB first. A host write while `st_read` is 1 sets `st_full`, which clears once the byte has been shifted out. The core never drives SDA during the controller's acknowledge bit.
- R8: When the controller answers a transmitted byte with NACK, `st_read` is 0 at that event, and the core releases SDA and sends nothing more until the next START.
- R9: A `wr_stb` while an address or data byte is shifting sets `st_wcol` and discards the write. `st_wcol` stays set until a `clr_wcol` pulse.
- R10: While `enable` is low, the transfer state returns to idle and all status flags clear. After re-enabling, bus clocks are ignored until a START.
- R11: An SCL pulse shorter than the filter length (3 system clocks by default) does not clock a bit into the core.
- R12: A repeated START in the middle of a transfer restarts the address phase. This allows a write to be followed by a read without a STOP in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Core enable; low forces idle and clears the status flags |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | The core's bus address |
| rd_data | output | 8 | Data register contents |
| rd_stb | input | 1 | Host has read the data register |
| wr_data | input | 8 | Byte to load into the data register |
| wr_stb | input | 1 | Load `wr_data` into the data register |
| clr_ovf | input | 1 | Clear the overflow flag |
| clr_wcol | input | 1 | Clear the write-collision flag |
| evt | output | 1 | Byte-step event pulse |
| st_start | output | 1 | START seen last |
| st_stop | output | 1 | STOP seen last |
| st_data | output | 1 | Last byte was data (1) or address (0) |
| st_read | output | 1 | Read transfer in progress |
| st_full | output | 1 | Data register holds an unconsumed byte |
| st_ovf | output | 1 | Receive overflow, sticky |
| st_wcol | output | 1 | Write collision, sticky |

## Verification
The hardest case to reach is the event that follows the controller's NACK of a transmitted byte. Reaching it needs a matched read address, a host write timed inside the high phase of the acknowledge clock so the next byte is queued, and then a second byte that the controller refuses. The bench's controller tasks release SDA for reads and insert the host write a quarter period after the ACK clock rises. They then end the second byte with NACK and clock eight more bits to confirm that the core stays silent. The overflow and collision cases are reached by skipping the host read between two received bytes, and by writing to the data register in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK,
      ST_WAIT
   } tgt_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_ev_t;
endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter bit RESET_VAL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_tgt_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("i2c_tgt_filter: FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{RESET_VAL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end
   assign sync_out = sync_q[SYNC_STAGES-1];

   if (FILT_LEN < 2) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= RESET_VAL;
         else        dout <= sync_out;
      end
   end else begin : g_agree
      logic [FILT_LEN-1:0] win;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win  <= {FILT_LEN{RESET_VAL}};
            dout <= RESET_VAL;
         end else begin
            win <= {win[FILT_LEN-2:0], sync_out};
            if (&win)       dout <= 1'b1;
            else if (~|win) dout <= 1'b0;
         end
      end

      // R11: a level change needs at least two agreeing samples behind it
      assert_filter_agree_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (dout != $past(dout)) |-> ($past(win[0]) == dout && $past(win[1]) == dout));
   end
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
   import i2c_tgt_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_f,
   input  logic    sda_f,
   output bus_ev_t ev
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   always_comb begin
      ev.rise  = scl_f & ~scl_d;
      ev.fall  = ~scl_f & scl_d;
      ev.start = scl_f & scl_d & sda_d & ~sda_f;
      ev.stop  = scl_f & scl_d & ~sda_d & sda_f;
      ev.sda   = sda_f;
   end

   // R1: a bus condition is never taken on an SCL edge
   assert_cond_no_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.start || ev.stop) |-> !(ev.rise || ev.fall));
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  bus_ev_t           ev,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic              clr_ovf,
   input  logic              clr_wcol,
   output logic [BYTE_W-1:0] dbuf,
   output logic              sda_oe,
   output logic              evt,
   output logic              st_start,
   output logic              st_stop,
   output logic              st_data,
   output logic              st_read,
   output logic              st_full,
   output logic              st_ovf,
   output logic              st_wcol
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

   tgt_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic              nack_q;
   logic              shifting;

   assign shifting = (state == ST_ADDR) || (state == ST_RX) || (state == ST_TX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         dbuf     <= '0;
         nack_q   <= 1'b0;
         sda_oe   <= 1'b0;
         evt      <= 1'b0;
         st_start <= 1'b0;
         st_stop  <= 1'b0;
         st_data  <= 1'b0;
         st_read  <= 1'b0;
         st_full  <= 1'b0;
         st_ovf   <= 1'b0;
         st_wcol  <= 1'b0;
      end else if (!enable) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         nack_q   <= 1'b0;
         sda_oe   <= 1'b0;
         evt      <= 1'b0;
         st_start <= 1'b0;
         st_stop  <= 1'b0;
         st_data  <= 1'b0;
         st_read  <= 1'b0;
         st_full  <= 1'b0;
         st_ovf   <= 1'b0;
         st_wcol  <= 1'b0;
      end else begin
         evt <= 1'b0;

         // host side
         if (clr_ovf)  st_ovf  <= 1'b0;
         if (clr_wcol) st_wcol <= 1'b0;
         if (rd_stb && !st_read) st_full <= 1'b0;
         if (wr_stb) begin
            if (shifting) st_wcol <= 1'b1;
            else begin
               dbuf <= wr_data;
               if (st_read) st_full <= 1'b1;
            end
         end

         // bus side
         if (ev.start) begin
            st_start <= 1'b1;
            st_stop  <= 1'b0;
            state    <= ST_ADDR;
            cnt      <= '0;
            sda_oe   <= 1'b0;
         end else if (ev.stop) begin
            st_stop  <= 1'b1;
            st_start <= 1'b0;
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_RX: begin
                  if (ev.rise) begin
                     shreg <= {shreg[BYTE_W-2:0], ev.sda};
                     cnt   <= cnt + 1'b1;
                  end else if (ev.fall && cnt == LAST_BIT) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (shreg[BYTE_W-1:1] == own_addr) begin
                           sda_oe <= 1'b1;
                           state  <= ST_AACK;
                        end else begin
                           state  <= ST_WAIT;
                        end
                     end else begin
                        state <= ST_RACK;
                        if (st_full) begin
                           st_ovf <= 1'b1;
                        end else begin
                           dbuf    <= shreg;
                           st_full <= 1'b1;
                           sda_oe  <= 1'b1;
                        end
                     end
                  end
               end
               ST_AACK: begin
                  if (ev.rise) begin
                     evt     <= 1'b1;
                     st_data <= 1'b0;
                     st_read <= shreg[0];
                  end else if (ev.fall) begin
                     cnt <= '0;
                     if (shreg[0]) begin
                        shreg  <= dbuf;
                        sda_oe <= ~dbuf[BYTE_W-1];
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_RACK: begin
                  if (ev.rise) begin
                     evt     <= 1'b1;
                     st_data <= 1'b1;
                  end else if (ev.fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (ev.fall) begin
                     if (cnt == LAST_TX) begin
                        sda_oe  <= 1'b0;
                        st_full <= 1'b0;
                        state   <= ST_TACK;
                     end else begin
                        cnt    <= cnt + 1'b1;
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               ST_TACK: begin
                  if (ev.rise) begin
                     evt     <= 1'b1;
                     st_data <= 1'b1;
                     nack_q  <= ev.sda;
                     if (ev.sda) st_read <= 1'b0;
                  end else if (ev.fall) begin
                     cnt <= '0;
                     if (nack_q) begin
                        state <= ST_WAIT;
                     end else begin
                        shreg  <= dbuf;
                        sda_oe <= ~dbuf[BYTE_W-1];
                        state  <= ST_TX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_evt_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
   assert_start_stop_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_start && st_stop));
   assert_ack_only_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_AACK) |-> (shreg[BYTE_W-1:1] == own_addr));
   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_ovf && enable && !clr_ovf) |=> st_ovf);
   assert_no_drive_tack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TACK) |-> !sda_oe);
   assert_nack_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TACK && ev.rise && ev.sda) |=> !st_read);
   assert_wcol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wcol && enable && !clr_wcol) |=> st_wcol);
   assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (state == ST_IDLE && !sda_oe && !evt && !st_full));
endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              rd_stb,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_stb,
   input  logic              clr_ovf,
   input  logic              clr_wcol,
   output logic              evt,
   output logic              st_start,
   output logic              st_stop,
   output logic              st_data,
   output logic              st_read,
   output logic              st_full,
   output logic              st_ovf,
   output logic              st_wcol
);
   localparam int N_LINES = 2;

   logic [N_LINES-1:0] raw_in;
   logic [N_LINES-1:0] filt;
   bus_ev_t            ev;

   assign raw_in = {sda_i, scl_i};

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      i2c_tgt_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN),
         .RESET_VAL  (1'b1)
      ) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_in[i]),
         .dout (filt[i])
      );
   end

   i2c_tgt_cond u_cond (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_f(filt[0]),
      .sda_f(filt[1]),
      .ev   (ev)
   );

   i2c_tgt_engine u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .ev      (ev),
      .own_addr(own_addr),
      .wr_data (wr_data),
      .wr_stb  (wr_stb),
      .rd_stb  (rd_stb),
      .clr_ovf (clr_ovf),
      .clr_wcol(clr_wcol),
      .dbuf    (rd_data),
      .sda_oe  (sda_oe),
      .evt     (evt),
      .st_start(st_start),
      .st_stop (st_stop),
      .st_data (st_data),
      .st_read (st_read),
      .st_full (st_full),
      .st_ovf  (st_ovf),
      .st_wcol (st_wcol)
   );
endmodule

// File: tb/sim_i2c_target_core.sv
module sim_i2c_target_core;
   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 10;
   localparam logic [6:0] OWN = 7'h42;
   // {expect ack, address, data}
   localparam logic [15:0] VEC [6] = '{
      {1'b1, 7'h42, 8'hA5}, {1'b0, 7'h43, 8'h5A}, {1'b1, 7'h42, 8'h00},
      {1'b0, 7'h02, 8'hFF}, {1'b1, 7'h42, 8'hFF}, {1'b0, 7'h7F, 8'h3C}};

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_line, sda_oe, rd_stb = 1'b0, wr_stb = 1'b0, clr_ovf = 1'b0, clr_wcol = 1'b0;
   logic [7:0] rd_data, wr_data = 8'h00;
   logic evt, st_start, st_stop, st_data, st_read, st_full, st_ovf, st_wcol;
   int n_chk = 0, n_fail = 0, ev_cnt = 0;
   logic ev_data_c = 1'b0, ev_read_c = 1'b0, ev_full_c = 1'b0;
   bit done = 1'b0;

   assign sda_line = sda_m & ~sda_oe;
   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_target_core u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .own_addr(OWN), .rd_data(rd_data), .rd_stb(rd_stb),
      .wr_data(wr_data), .wr_stb(wr_stb), .clr_ovf(clr_ovf), .clr_wcol(clr_wcol),
      .evt(evt), .st_start(st_start), .st_stop(st_stop), .st_data(st_data),
      .st_read(st_read), .st_full(st_full), .st_ovf(st_ovf), .st_wcol(st_wcol));

   always @(negedge clk) if (evt) begin
      ev_cnt++;
      ev_data_c = st_data;
      ev_read_c = st_read;
      ev_full_c = st_full;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n * QTR) @(negedge clk);
   endtask

   task automatic host_write(input logic [7:0] d);
      @(negedge clk); wr_data = d; wr_stb = 1'b1;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic pulse_rd();
      @(negedge clk); rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic bus_start();
      sda_m = 1'b0; wq(2); scl_m = 1'b0;
   endtask

   task automatic bus_rstart();
      wq(1); sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
   endtask

   task automatic bit_out(input logic b, input bit glitch);
      wq(1); sda_m = b;
      if (glitch) begin
         @(negedge clk); scl_m = 1'b1; @(negedge clk); scl_m = 1'b0;
      end
      wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0;
   endtask

   task automatic bit_in(output logic b);
      wq(1); sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); b = sda_line; wq(1); scl_m = 1'b0;
   endtask

   task automatic write_byte(input logic [7:0] d, input bit glitch, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) bit_out(d[i], glitch);
      bit_in(b);
      ack = ~b;
   endtask

   task automatic read_byte(input bit m_ack, input bit host_en, input logic [7:0] nxt,
                            output logic [7:0] d, output logic drove);
      for (int i = 7; i >= 0; i--) bit_in(d[i]);
      wq(1); sda_m = ~m_ack; wq(1); scl_m = 1'b1; wq(1);
      drove = sda_oe;
      if (host_en) host_write(nxt);
      wq(1); scl_m = 1'b0;
   endtask

   initial begin
      logic ack;
      logic drove;
      logic [7:0] d;
      int e0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // reset state
      chk("R1 reset flags", {st_start, st_stop, st_data, st_read}, 4'h0);
      chk("R6 reset ovf/wcol/full", {st_ovf, st_wcol, st_full, sda_oe}, 4'h0);

      // table of write transfers
      for (int i = 0; i < 6; i++) begin
         e0 = ev_cnt;
         bus_start();
         chk("R1 start flag", {st_start, st_stop}, 2'b10);
         write_byte({VEC[i][14:8], 1'b0}, 1'b0, ack);
         chk("R2 address ack", ack, VEC[i][15]);
         if (VEC[i][15]) begin
            chk("R4 addr event data flag", ev_data_c, 1'b0);
            chk("R4 addr event read flag", ev_read_c, 1'b0);
         end
         write_byte(VEC[i][7:0], 1'b0, ack);
         chk("R5 data ack", ack, VEC[i][15]);
         if (VEC[i][15]) begin
            chk("R5 received byte", rd_data, VEC[i][7:0]);
            chk("R5 full set", st_full, 1'b1);
            chk("R3 two events", ev_cnt - e0, 2);
            chk("R4 data event flag", ev_data_c, 1'b1);
            pulse_rd();
            chk("R5 full cleared by read", st_full, 1'b0);
         end else begin
            chk("R2 no event on mismatch", ev_cnt - e0, 0);
         end
         bus_stop();
         chk("R1 stop flag", {st_start, st_stop}, 2'b01);
      end

      // overflow
      bus_start();
      write_byte({OWN, 1'b0}, 1'b0, ack);
      write_byte(8'h3E, 1'b0, ack);
      write_byte(8'hC1, 1'b0, ack);
      chk("R6 overflow nack", ack, 1'b0);
      chk("R6 overflow flag", st_ovf, 1'b1);
      chk("R6 buffer kept", rd_data, 8'h3E);
      bus_stop();
      chk("R6 ovf sticky", st_ovf, 1'b1);
      @(negedge clk); clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
      chk("R6 ovf cleared", st_ovf, 1'b0);
      pulse_rd();

      // read transfer with ACK then NACK
      host_write(8'hC3);
      bus_start();
      write_byte({OWN, 1'b1}, 1'b0, ack);
      chk("R2 read address ack", ack, 1'b1);
      chk("R4 read flag at addr event", {ev_read_c, ev_data_c}, 2'b10);
      e0 = ev_cnt;
      read_byte(1'b1, 1'b1, 8'h96, d, drove);
      chk("R7 first tx byte", d, 8'hC3);
      chk("R7 no drive on master ack", drove, 1'b0);
      chk("R3 event after ack", ev_cnt - e0, 1);
      chk("R7 full after host write", st_full, 1'b1);
      read_byte(1'b0, 1'b0, 8'h00, d, drove);
      chk("R7 second tx byte", d, 8'h96);
      chk("R7 full clear after shift", ev_full_c, 1'b0);
      chk("R3 event after nack", ev_cnt - e0, 2);
      chk("R8 read flag cleared at nack", ev_read_c, 1'b0);
      for (int i = 7; i >= 0; i--) bit_in(d[i]);
      chk("R8 silent after nack", d, 8'hFF);
      bus_stop();

      // write collision
      bus_start();
      write_byte({OWN, 1'b0}, 1'b0, ack);
      bit_out(1'b0, 1'b0); bit_out(1'b1, 1'b0); bit_out(1'b1, 1'b0);
      host_write(8'hEE);
      chk("R9 wcol set", st_wcol, 1'b1);
      chk("R9 write discarded", rd_data, 8'h96);
      for (int i = 4; i >= 0; i--) bit_out(1'b1, 1'b0);
      bit_in(ack);
      chk("R9 byte after collision", rd_data, 8'h7F);
      bus_stop();
      chk("R9 wcol sticky", st_wcol, 1'b1);
      @(negedge clk); clr_wcol = 1'b1; @(negedge clk); clr_wcol = 1'b0;
      chk("R9 wcol cleared", st_wcol, 1'b0);
      pulse_rd();

      // repeated start
      bus_start();
      write_byte({OWN, 1'b0}, 1'b0, ack);
      write_byte(8'h11, 1'b0, ack);
      pulse_rd();
      bus_rstart();
      write_byte({OWN, 1'b1}, 1'b0, ack);
      chk("R12 ack after repeated start", ack, 1'b1);
      chk("R12 read flag", ev_read_c, 1'b1);
      read_byte(1'b0, 1'b0, 8'h00, d, drove);
      chk("R12 read data", d, 8'h11);
      bus_stop();

      // glitch filter
      bus_start();
      write_byte({OWN, 1'b0}, 1'b1, ack);
      chk("R11 addr ack with glitches", ack, 1'b1);
      write_byte(8'hA5, 1'b1, ack);
      chk("R11 byte with glitches", rd_data, 8'hA5);
      pulse_rd();
      bus_stop();

      // disable mid transfer
      bus_start();
      write_byte({OWN, 1'b0}, 1'b0, ack);
      @(negedge clk); enable = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 flags cleared", {st_start, st_data, st_full, sda_oe}, 4'h0);
      enable = 1'b1;
      e0 = ev_cnt;
      write_byte(8'h55, 1'b0, ack);
      chk("R10 byte ignored after re-enable", {ack, 1'b0}, 2'b00);
      chk("R10 no event after re-enable", ev_cnt - e0, 0);
      bus_stop();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule